// File: doc/BRIEF.md
# Transmit Descriptor Sequencer

This block drives a frame transmitter from a ring of buffer descriptors held in a local 256-entry table. Each descriptor says whether it is ready for use, whether the ring should jump back to entry 0 after it, and how many data words the frame carries. The sequencer reads one descriptor, moves that many words from a bus-side source to the transmit side under valid/ready handshaking, and then moves on to the next entry.

Two control bits govern it. The enable bit is also a soft reset. While it is low, the engine sits in IDLE with every counter and pointer cleared, and the descriptor table refuses processor access. The request-enable bit gates the start of new frames. Clearing it never truncates a frame. The engine finishes the current frame, stops in STALLED and publishes the index of the next descriptor it would read. An unready descriptor parks the engine in WAIT_RESTART until the restart bit changes level. A request-enable clear that arrives during that wait is deferred until the restart toggle.

States and transitions: IDLE→FETCH when requests are enabled. FETCH→XFER for a ready descriptor. FETCH→WAIT_RESTART for an unready descriptor. FETCH→STALLED if requests were withdrawn. XFER→END_FRAME on acceptance of the last word. END_FRAME→FETCH, or END_FRAME→STALLED if requests are off. STALLED→FETCH when requests return. WAIT_RESTART→FETCH, or WAIT_RESTART→STALLED, on a restart toggle. Any state→IDLE while the enable bit is low.

Top module: `tx_desc_sequencer`

## Requirements
- R1: While `tx_en` is 0 the engine is held in IDLE on the next clock: `dreq`, `tx_valid` and `done` are 0, and `stall_ptr` is 0. Descriptor table contents are retained, and `cpu_rdata` reads 0.
- R2: A processor write (`cpu_we`) changes the table only while `tx_en` is 1. While `tx_en` is 1, `cpu_rdata` returns the entry at `cpu_addr` combinationally.
- R3: Descriptor encoding: bit 9 is the ready flag, bit 8 is the wrap flag, and bits 7:0 hold the word count minus one. A frame carries count+1 words, and `tx_last` marks the final one.
- R4: In XFER, `tx_valid` follows `in_valid`, `tx_data` follows `in_data` and `in_ready` follows `tx_ready`. A word is consumed only when `in_valid` and `tx_ready` are both 1. Outside XFER, `tx_valid` and `in_ready` are 0.
- R5: `dreq` is high exactly in XFER. It rises only in the cycle after a FETCH that saw `dma_en` high.
- R6: Clearing `dma_en` lets the current frame finish. The engine then enters STALLED, and `stall_ptr` holds the index that follows the finished frame.
- R7: After a frame, the next index is the current index plus one, taken modulo 256. A descriptor with the wrap flag sends the next index to 0.
- R8: An unready descriptor moves FETCH→WAIT_RESTART and sets `stall_ptr` to its index. A change of `restart` level then resumes FETCH at that index.
- R9: In WAIT_RESTART a low `dma_en` has no effect until `restart` toggles. At the toggle the engine enters STALLED instead of FETCH, and `stall_ptr` is unchanged.
- R10: In STALLED, `stall_ptr` holds steady while `dma_en` is 0. Raising `dma_en` resumes FETCH at `stall_ptr` without any reset.
- R11: `done` is a one-cycle pulse in END_FRAME, the cycle after the last word is accepted, once per frame.
- R12: After reset, raising `dma_en` starts fetching at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable, soft reset when low |
| dma_en | input | 1 | Permits new frame requests |
| restart | input | 1 | Level toggle that releases WAIT_RESTART |
| cpu_we | input | 1 | Processor write strobe to the descriptor table |
| cpu_addr | input | 8 | Processor table index |
| cpu_wdata | input | 10 | Descriptor written |
| cpu_rdata | output | 10 | Descriptor read, 0 while disabled |
| dreq | output | 1 | Data request toward the bus side |
| in_valid | input | 1 | Bus-side word valid |
| in_data | input | 32 | Bus-side word |
| in_ready | output | 1 | Bus-side word accepted |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit word |
| tx_last | output | 1 | Final word of the frame |
| tx_ready | input | 1 | Transmit side ready |
| done | output | 1 | Frame-complete pulse |
| stall_ptr | output | 8 | Next descriptor index saved at a stop |

## Verification
A wrong word count shows up as `tx_last` on the wrong word, or as a `done` pulse shifted by at least one cycle. A bad index shows up at the next stop as a wrong `stall_ptr`, or as frame lengths that do not follow the programmed ring. A state machine that leaves STALLED or WAIT_RESTART early raises `dreq` two cycles later. One that ignores the soft reset keeps `dreq` high one cycle after `tx_en` falls. The bench compares every output against its model on every clock, so each such fault is caught within a cycle or two of its first visible effect.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_XFER,
        S_END_FRAME,
        S_STALLED,
        S_WAIT_RESTART
    } seq_state_e;

endpackage

// File: rtl/txseq_desc_ram.sv
module txseq_desc_ram #(
    parameter int IDX_W = 8,
    parameter int ENT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [ENT_W-1:0] host_wdata,
    output logic [ENT_W-1:0] host_rdata,
    input  logic [IDX_W-1:0] eng_idx,
    output logic [ENT_W-1:0] eng_rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] table_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) table_q[i] <= '0;
        end else if (en && wr) begin
            table_q[host_idx] <= host_wdata;
        end
    end

    assign host_rdata = en ? table_q[host_idx] : '0;
    assign eng_rdata  = table_q[eng_idx];

endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
    import txseq_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               dma_en,
    input  logic               restart,
    output logic [IDX_W-1:0]   desc_idx,
    input  logic [LEN_W+1:0]   desc,
    input  logic               in_valid,
    input  logic               tx_ready,
    output logic               dreq,
    output logic               tx_valid,
    output logic               in_ready,
    output logic               tx_last,
    output logic               done,
    output logic [IDX_W-1:0]   stall_ptr
);
    localparam int RDY_BIT  = LEN_W + 1;
    localparam int WRAP_BIT = LEN_W;
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    seq_state_e       state_q, state_n;
    logic [IDX_W-1:0] ptr_q, ptr_n;
    logic [IDX_W-1:0] stall_q, stall_n;
    logic [LEN_W-1:0] cnt_q, cnt_n;
    logic [LEN_W-1:0] len_q, len_n;
    logic             wrap_q, wrap_n;
    logic             restart_q;
    logic             toggled;
    logic             beat;
    logic [IDX_W-1:0] next_idx;

    assign toggled  = (restart != restart_q);
    assign beat     = (state_q == S_XFER) && in_valid && tx_ready;
    assign next_idx = (wrap_q || ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;

    always_comb begin
        state_n = state_q;
        ptr_n   = ptr_q;
        stall_n = stall_q;
        cnt_n   = cnt_q;
        len_n   = len_q;
        wrap_n  = wrap_q;
        if (!tx_en) begin
            state_n = S_IDLE;
            ptr_n   = '0;
            stall_n = '0;
            cnt_n   = '0;
            len_n   = '0;
            wrap_n  = 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (dma_en) state_n = S_FETCH;
                S_FETCH: begin
                    if (!dma_en) begin
                        state_n = S_STALLED;
                        stall_n = ptr_q;
                    end else if (!desc[RDY_BIT]) begin
                        state_n = S_WAIT_RESTART;
                        stall_n = ptr_q;
                    end else begin
                        state_n = S_XFER;
                        len_n   = desc[LEN_W-1:0];
                        wrap_n  = desc[WRAP_BIT];
                        cnt_n   = '0;
                    end
                end
                S_XFER: begin
                    if (beat) begin
                        if (cnt_q == len_q) state_n = S_END_FRAME;
                        else                cnt_n   = cnt_q + 1'b1;
                    end
                end
                S_END_FRAME: begin
                    ptr_n = next_idx;
                    if (dma_en) begin
                        state_n = S_FETCH;
                    end else begin
                        state_n = S_STALLED;
                        stall_n = next_idx;
                    end
                end
                S_STALLED: begin
                    if (dma_en) begin
                        state_n = S_FETCH;
                        ptr_n   = stall_q;
                    end
                end
                S_WAIT_RESTART: begin
                    if (toggled) state_n = dma_en ? S_FETCH : S_STALLED;
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            ptr_q     <= '0;
            stall_q   <= '0;
            cnt_q     <= '0;
            len_q     <= '0;
            wrap_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            ptr_q     <= ptr_n;
            stall_q   <= stall_n;
            cnt_q     <= cnt_n;
            len_q     <= len_n;
            wrap_q    <= wrap_n;
            restart_q <= restart;
        end
    end

    always_comb begin
        desc_idx  = ptr_q;
        stall_ptr = stall_q;
        dreq      = (state_q == S_XFER);
        tx_valid  = (state_q == S_XFER) && in_valid;
        in_ready  = (state_q == S_XFER) && tx_ready;
        tx_last   = (state_q == S_XFER) && (cnt_q == len_q);
        done      = (state_q == S_END_FRAME);
    end

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state_q == S_IDLE) && (stall_ptr == '0) && !dreq) // R1
        else $error("soft reset not honoured");

    AST_DREQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq) |-> $past(dma_en)) // R5
        else $error("request started without enable");

    AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_valid && tx_ready && tx_last) |=> done) // R3
        else $error("last word not followed by done");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R11
        else $error("done longer than one cycle");

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && state_q == S_STALLED && !dma_en) |=>
            (state_q == S_STALLED) && $stable(stall_ptr)) // R10
        else $error("stall not held");

    AST_WAIT_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && state_q == S_WAIT_RESTART && !toggled) |=>
            (state_q == S_WAIT_RESTART)) // R9
        else $error("wait left without restart toggle");

endmodule

// File: rtl/tx_desc_sequencer.sv
module tx_desc_sequencer #(
    parameter int IDX_W  = 8,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              dma_en,
    input  logic              restart,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_addr,
    input  logic [LEN_W+1:0]  cpu_wdata,
    output logic [LEN_W+1:0]  cpu_rdata,
    output logic              dreq,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              done,
    output logic [IDX_W-1:0]  stall_ptr
);
    localparam int DESC_W = LEN_W + 2;

    logic [IDX_W-1:0]  eng_idx;
    logic [DESC_W-1:0] eng_desc;

    txseq_desc_ram #(.IDX_W(IDX_W), .ENT_W(DESC_W)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (tx_en),
        .wr         (cpu_we),
        .host_idx   (cpu_addr),
        .host_wdata (cpu_wdata),
        .host_rdata (cpu_rdata),
        .eng_idx    (eng_idx),
        .eng_rdata  (eng_desc)
    );

    txseq_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .dma_en    (dma_en),
        .restart   (restart),
        .desc_idx  (eng_idx),
        .desc      (eng_desc),
        .in_valid  (in_valid),
        .tx_ready  (tx_ready),
        .dreq      (dreq),
        .tx_valid  (tx_valid),
        .in_ready  (in_ready),
        .tx_last   (tx_last),
        .done      (done),
        .stall_ptr (stall_ptr)
    );

    assign tx_data = in_data;

endmodule

// File: tb/tx_desc_sequencer_bench.sv
`timescale 1ns/1ps
module tx_desc_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, dma_en = 1'b0, restart = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [9:0]  cpu_wdata = '0;
    logic [9:0]  cpu_rdata;
    logic        dreq, in_valid = 1'b0, in_ready, tx_valid, tx_last, tx_ready = 1'b0, done;
    logic [31:0] in_data = '0, tx_data;
    logic [7:0]  stall_ptr;

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    int pat = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tx_desc_sequencer u_tx_desc_sequencer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dma_en(dma_en), .restart(restart),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dreq(dreq), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .done(done), .stall_ptr(stall_ptr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: 0 idle, 1 fetch, 2 xfer, 3 end, 4 stalled, 5 wait
    int         m_st = 0, m_ptr = 0, m_stall = 0, m_cnt = 0, m_len = 0;
    bit         m_wrap = 0, m_rq = 0;
    logic [9:0] m_tab [256];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_stall = 0; m_cnt = 0; m_len = 0; m_wrap = 0; m_rq = 0;
            for (int i = 0; i < 256; i++) m_tab[i] = '0;
        end else begin
            if (!tx_en) begin
                m_st = 0; m_ptr = 0; m_stall = 0; m_cnt = 0; m_len = 0; m_wrap = 0;
            end else begin
                case (m_st)
                    0: if (dma_en) m_st = 1;
                    1: if (!dma_en) begin m_st = 4; m_stall = m_ptr; end
                       else if (!m_tab[m_ptr][9]) begin m_st = 5; m_stall = m_ptr; end
                       else begin m_len = m_tab[m_ptr][7:0]; m_wrap = m_tab[m_ptr][8]; m_cnt = 0; m_st = 2; end
                    2: if (in_valid && tx_ready) begin
                           if (m_cnt == m_len) m_st = 3; else m_cnt++;
                       end
                    3: begin
                           m_ptr = m_wrap ? 0 : (m_ptr + 1) % 256;
                           if (dma_en) m_st = 1; else begin m_st = 4; m_stall = m_ptr; end
                       end
                    4: if (dma_en) begin m_st = 1; m_ptr = m_stall; end
                    5: if (restart != m_rq) m_st = dma_en ? 1 : 4;
                    default: m_st = 0;
                endcase
                if (cpu_we) m_tab[cpu_addr] = cpu_wdata;
            end
            m_rq = restart;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (pat == 0) begin
            in_valid = 1'b1; tx_ready = 1'b1;
        end else begin
            in_valid = (cyc % 3) != 0;
            tx_ready = (cyc % 5) != 2;
        end
        in_data = cyc * 7 + 3;
        #1;
        if (rst_n && !finished) begin
            check("R5 dreq", dreq, m_st == 2);
            check("R4 tx_valid", tx_valid, (m_st == 2) && in_valid);
            check("R4 in_ready", in_ready, (m_st == 2) && tx_ready);
            if (tx_valid) check("R4 tx_data", tx_data, in_data);
            check("R3 tx_last", tx_last, (m_st == 2) && (m_cnt == m_len));
            check("R11 done", done, m_st == 3);
            check("R6 R7 stall_ptr", stall_ptr, m_stall);
            check("R2 cpu_rdata", cpu_rdata, tx_en ? m_tab[cpu_addr] : 10'h0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_wr(input logic [7:0] a, input logic [9:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic wait_done(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk); #2;
            if (done) k++;
        end
    endtask

    initial begin
        step(3);
        #2;
        check("R1 reset dreq", dreq, 0);
        check("R1 reset done", done, 0);
        check("R1 reset stall_ptr", stall_ptr, 0);
        check("R1 reset tx_valid", tx_valid, 0);
        rst_n = 1'b1;
        step(2);
        cpu_wr(8'd10, 10'h3FF);
        #2 check("R2 disabled read", cpu_rdata, 0);
        tx_en = 1'b1;
        step(1);
        cpu_addr = 8'd10; #2 check("R2 write ignored", cpu_rdata, 0);
        cpu_wr(8'd0, 10'h202);
        cpu_wr(8'd1, 10'h200);
        cpu_wr(8'd2, 10'h201);
        cpu_wr(8'd3, 10'h300);
        cpu_addr = 8'd3; #2 check("R2 readback", cpu_rdata, 10'h300);

        dma_en = 1'b1;
        wait_done(1);
        dma_en = 1'b0;
        step(4); #2;
        check("R12 R6 stall after frame 0", stall_ptr, 1);
        check("R6 no request", dreq, 0);
        step(5); #2;
        check("R10 stall held", stall_ptr, 1);
        dma_en = 1'b1;
        wait_done(3);
        dma_en = 1'b0;
        step(4); #2;
        check("R7 wrap flag", stall_ptr, 0);

        cpu_wr(8'd1, 10'h000);
        cpu_wr(8'd2, 10'h000);
        dma_en = 1'b1;
        wait_done(1);
        step(4); #2;
        check("R8 parked index", stall_ptr, 1);
        check("R8 parked no request", dreq, 0);
        dma_en = 1'b0;
        step(5); #2;
        check("R9 still parked", stall_ptr, 1);
        cpu_wr(8'd1, 10'h200);
        restart = 1'b1;
        step(3); #2;
        check("R9 no request after deferred clear", dreq, 0);
        check("R9 index kept", stall_ptr, 1);
        dma_en = 1'b1;
        wait_done(1);
        step(4); #2;
        check("R8 second park", stall_ptr, 2);
        cpu_wr(8'd2, 10'h201);
        restart = 1'b0;
        step(2); #2;
        check("R8 resumed request", dreq, 1);

        tx_en = 1'b0;
        cpu_addr = 8'd0;
        step(1); #2;
        check("R1 soft reset dreq", dreq, 0);
        check("R1 soft reset ptr", stall_ptr, 0);
        check("R1 soft reset read", cpu_rdata, 0);
        tx_en = 1'b1;
        step(1); #2;
        check("R1 table retained", cpu_rdata, 10'h202);

        dma_en = 1'b0;
        step(12);
        for (int i = 0; i < 256; i++) cpu_wr(i[7:0], 10'h200 | 10'(i % 4));
        pat = 1;
        dma_en = 1'b1;
        for (int j = 0; j < 4; j++) begin
            step(700);
            dma_en = ~dma_en;
        end
        dma_en = 1'b0;
        step(30);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule